// File: doc/BRIEF.md
# Circular-Buffer Data Address Generator

This block produces memory addresses for one data bus. It holds eight register sets. Each set has four 32-bit registers: a pointer, a step, a buffer start and a buffer size. On each request the caller names a set and an addressing mode, and the block returns a registered address one clock later. In the two post-modify modes it also writes the moved pointer back. In the circular mode the moved pointer wraps at the edges of the buffer held in the same set, so it never leaves `[start, start+size)`.

The register sets fall into two halves, each with a primary and an alternate copy. Each half has its own select bit in `bank_mode`. Flipping a bit gives an interrupt handler or a second task a fresh set of pointers without saving the old ones. The flip takes effect two clock edges after the bit changes. A single write port loads any register of the copy that is currently active.

Top module: `circbuf_agen`

## Requirements
- R1: A synchronous active-high `rst` clears `addr_valid`, `addr_out`, every register of both copies and both bank selects, so an access to an untouched set returns address 0.
- R2: When `wr_en` is high, `wr_data` is written at the next edge into the register picked by `wr_field` of set `wr_set`, in the copy currently active for that set's half. The `wr_field` codes are 0 = pointer, 1 = step, 2 = start, 3 = size.
- R3: `req_mode` 0 (linear) issues the pointer as the address and writes back pointer + step. The step may be negative in two's complement.
- R4: `req_mode` 1 (circular) issues the pointer and writes back `((pointer - start + step) mod size) + start`. This requires `|step| <= size` and a pointer inside the buffer. A step going past the top subtracts the size, and a step going below the start adds the size. When size is 0 the update is linear.
- R5: `req_mode` 2 issues pointer + `req_imm`, and `req_mode` 3 issues pointer + step. Neither mode changes the pointer.
- R6: `addr_out` and `addr_valid` are registered. A request sampled at edge E appears after E. Without a request `addr_valid` is 0 after the edge and `addr_out` holds its last value.
- R7: Sets 0 to 3 form half 0, selected by `bank_mode[0]`, and sets 4 to 7 form half 1, selected by `bank_mode[1]`. A value of 1 selects the alternate copy. Switching one half leaves the other half's registers in use.
- R8: If `bank_mode` changes before edge E, requests at edges E and E+1 still use the old copy, and requests from E+2 onward use the new one.
- R9: If a pointer write and a pointer update hit the same register at the same edge, the written value is kept. The address issued is still the old pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bank_mode | input | 2 | Per-half copy select, 1 = alternate |
| wr_en | input | 1 | Register write strobe |
| wr_set | input | 3 | Set written |
| wr_field | input | 2 | Register written: 0 pointer, 1 step, 2 start, 3 size |
| wr_data | input | 32 | Value written |
| req_valid | input | 1 | Access request |
| req_set | input | 3 | Set used by the access |
| req_mode | input | 2 | 0 linear, 1 circular, 2 pointer+immediate, 3 pointer+step |
| req_imm | input | 32 | Immediate offset for mode 2 |
| addr_valid | output | 1 | Registered: address issued this cycle |
| addr_out | output | 32 | Registered issued address |

## Verification
The checker watches every cycle for the following:
- a request always yields a valid address one edge later, and an idle cycle never does;
- the offset modes never enable a pointer write-back;
- a legal circular step always lands inside the buffer;
- a size of 0 reduces the circular update to a plain addition;
- the active copy selects change only one edge after the staged selects change.

Only the bench scenarios can show the following:
- the actual wrap values in both directions;
- the exact two-edge delay of a copy switch, and that the two halves stay independent;
- that a write beats an update on the same register;
- that the offset modes leave the pointer untouched when the set is read again later.

// File: rtl/circbuf_agen_pkg.sv
package circbuf_agen_pkg;

  typedef enum logic [1:0] {
    AM_LINEAR  = 2'd0,
    AM_CIRC    = 2'd1,
    AM_OFS_IMM = 2'd2,
    AM_OFS_MOD = 2'd3
  } amode_e;

  typedef enum logic [1:0] {
    FLD_PTR   = 2'd0,
    FLD_STEP  = 2'd1,
    FLD_START = 2'd2,
    FLD_SIZE  = 2'd3
  } field_e;

endpackage

// File: rtl/cag_bank_pipe.sv
// Two-stage pipeline on the per-half copy selects: a staged value
// followed by the value actually used to address the register file.
module cag_bank_pipe #(
  parameter int SEGS = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [SEGS-1:0] sel_in,
  output logic [SEGS-1:0] sel_stage,
  output logic [SEGS-1:0] sel_active
);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_stage  <= '0;
      sel_active <= '0;
    end else begin
      sel_stage  <= sel_in;
      sel_active <= sel_stage;
    end
  end

endmodule

// File: rtl/cag_regs.sv
// Register sets, two copies each. Four parallel reads of one set,
// one software write port, one pointer write-back port.
module cag_regs
  import circbuf_agen_pkg::*;
#(
  parameter int W     = 32,
  parameter int SETS  = 8,
  parameter int SEGS  = 2,
  localparam int SET_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEGS-1:0]  active,
  input  logic [SET_W-1:0] rd_set,
  output logic [W-1:0]     rd_ptr,
  output logic [W-1:0]     rd_step,
  output logic [W-1:0]     rd_start,
  output logic [W-1:0]     rd_size,
  input  logic             wr_en,
  input  logic [SET_W-1:0] wr_set,
  input  field_e           wr_field,
  input  logic [W-1:0]     wr_data,
  input  logic             upd_en,
  input  logic [SET_W-1:0] upd_set,
  input  logic [W-1:0]     upd_val
);

  localparam int SEG_SETS = SETS / SEGS;
  localparam int ENTRIES  = 2 * SETS;
  localparam int PH_W     = SET_W + 1;

  function automatic logic [PH_W-1:0] phys(input logic [SET_W-1:0] s,
                                           input logic [SEGS-1:0] act);
    int seg;
    seg = int'(s) / SEG_SETS;
    return {act[seg], s};
  endfunction

  logic [W-1:0] ptr_q   [ENTRIES];
  logic [W-1:0] step_q  [ENTRIES];
  logic [W-1:0] start_q [ENTRIES];
  logic [W-1:0] size_q  [ENTRIES];

  logic [PH_W-1:0] rd_ph, wr_ph, upd_ph;

  assign rd_ph  = phys(rd_set, active);
  assign wr_ph  = phys(wr_set, active);
  assign upd_ph = phys(upd_set, active);

  assign rd_ptr   = ptr_q[rd_ph];
  assign rd_step  = step_q[rd_ph];
  assign rd_start = start_q[rd_ph];
  assign rd_size  = size_q[rd_ph];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    localparam logic [PH_W-1:0] ME = PH_W'(g);
    logic wr_hit, upd_hit;
    assign wr_hit  = wr_en && (wr_ph == ME);
    assign upd_hit = upd_en && (upd_ph == ME);

    // Pointer: a software write outranks the access write-back.
    always_ff @(posedge clk) begin
      if (rst) begin
        ptr_q[g] <= '0;
      end else if (wr_hit && wr_field == FLD_PTR) begin
        ptr_q[g] <= wr_data;
      end else if (upd_hit) begin
        ptr_q[g] <= upd_val;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        step_q[g]  <= '0;
        start_q[g] <= '0;
        size_q[g]  <= '0;
      end else if (wr_hit) begin
        case (wr_field)
          FLD_STEP:  step_q[g]  <= wr_data;
          FLD_START: start_q[g] <= wr_data;
          FLD_SIZE:  size_q[g]  <= wr_data;
          default:   ;
        endcase
      end
    end
  end

endmodule

// File: rtl/cag_step.sv
// Address and next-pointer arithmetic for one access.
module cag_step
  import circbuf_agen_pkg::*;
#(
  parameter int W = 32
) (
  input  amode_e       mode,
  input  logic [W-1:0] ptr,
  input  logic [W-1:0] step,
  input  logic [W-1:0] start,
  input  logic [W-1:0] size,
  input  logic [W-1:0] imm,
  output logic [W-1:0] issue_addr,
  output logic [W-1:0] next_ptr,
  output logic         upd_en
);

  logic [W:0]   rel;
  logic [W:0]   moved;
  logic [W:0]   wrapped;
  logic [W-1:0] circ_ptr;
  logic [W-1:0] lin_ptr;

  assign lin_ptr = ptr + step;
  assign rel     = {1'b0, ptr} - {1'b0, start};
  assign moved   = rel + {step[W-1], step};

  always_comb begin
    wrapped = moved;
    if (!step[W-1]) begin
      if (moved >= {1'b0, size}) wrapped = moved - {1'b0, size};
    end else begin
      if (moved[W]) wrapped = moved + {1'b0, size};
    end
  end

  assign circ_ptr = (size == '0) ? lin_ptr : (start + wrapped[W-1:0]);

  always_comb begin
    issue_addr = ptr;
    next_ptr   = ptr;
    upd_en     = 1'b0;
    unique case (mode)
      AM_LINEAR: begin
        next_ptr = lin_ptr;
        upd_en   = 1'b1;
      end
      AM_CIRC: begin
        next_ptr = circ_ptr;
        upd_en   = 1'b1;
      end
      AM_OFS_IMM: issue_addr = ptr + imm;
      AM_OFS_MOD: issue_addr = ptr + step;
      default:    ;
    endcase
  end

endmodule

// File: rtl/circbuf_agen.sv
module circbuf_agen
  import circbuf_agen_pkg::*;
#(
  parameter int W    = 32,
  parameter int SETS = 8,
  parameter int SEGS = 2,
  localparam int SET_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEGS-1:0]  bank_mode,
  input  logic             wr_en,
  input  logic [SET_W-1:0] wr_set,
  input  logic [1:0]       wr_field,
  input  logic [W-1:0]     wr_data,
  input  logic             req_valid,
  input  logic [SET_W-1:0] req_set,
  input  logic [1:0]       req_mode,
  input  logic [W-1:0]     req_imm,
  output logic             addr_valid,
  output logic [W-1:0]     addr_out
);

  logic [SEGS-1:0] sel_stage, sel_active;
  logic [W-1:0]    cur_ptr, cur_step, cur_start, cur_size;
  logic [W-1:0]    issue_addr, next_ptr;
  logic            step_upd, upd_en;

  cag_bank_pipe #(.SEGS(SEGS)) bank_i (
    .clk        (clk),
    .rst        (rst),
    .sel_in     (bank_mode),
    .sel_stage  (sel_stage),
    .sel_active (sel_active)
  );

  cag_regs #(.W(W), .SETS(SETS), .SEGS(SEGS)) regs_i (
    .clk      (clk),
    .rst      (rst),
    .active   (sel_active),
    .rd_set   (req_set),
    .rd_ptr   (cur_ptr),
    .rd_step  (cur_step),
    .rd_start (cur_start),
    .rd_size  (cur_size),
    .wr_en    (wr_en),
    .wr_set   (wr_set),
    .wr_field (field_e'(wr_field)),
    .wr_data  (wr_data),
    .upd_en   (upd_en),
    .upd_set  (req_set),
    .upd_val  (next_ptr)
  );

  cag_step #(.W(W)) step_i (
    .mode       (amode_e'(req_mode)),
    .ptr        (cur_ptr),
    .step       (cur_step),
    .start      (cur_start),
    .size       (cur_size),
    .imm        (req_imm),
    .issue_addr (issue_addr),
    .next_ptr   (next_ptr),
    .upd_en     (step_upd)
  );

  assign upd_en = req_valid && step_upd;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_valid <= 1'b0;
      addr_out   <= '0;
    end else begin
      addr_valid <= req_valid;
      if (req_valid) addr_out <= issue_addr;
    end
  end

endmodule

// File: rtl/circbuf_agen_chk.sv
module circbuf_agen_chk #(
  parameter int W    = 32,
  parameter int SEGS = 2
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic [1:0]      req_mode,
  input logic            addr_valid,
  input logic [W-1:0]    addr_out,
  input logic [W-1:0]    cur_ptr,
  input logic [W-1:0]    cur_step,
  input logic [W-1:0]    cur_start,
  input logic [W-1:0]    cur_size,
  input logic [W-1:0]    next_ptr,
  input logic            upd_en,
  input logic [SEGS-1:0] sel_stage,
  input logic [SEGS-1:0] sel_active
);

  logic in_buf, step_ok, lands_in;
  logic [W-1:0] neg_step;

  assign neg_step = -cur_step;
  assign in_buf   = (cur_ptr >= cur_start) && ((cur_ptr - cur_start) < cur_size);
  assign step_ok  = cur_step[W-1] ? (neg_step <= cur_size) : (cur_step <= cur_size);
  assign lands_in = (next_ptr >= cur_start) && ((next_ptr - cur_start) < cur_size);

  assert_valid_follows_R6: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> addr_valid);

  assert_idle_no_valid_R6: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !addr_valid);

  assert_offset_no_update_R5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_mode[1]) |-> !upd_en);

  assert_circ_in_range_R4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_mode == 2'd1 && cur_size != '0 && in_buf && step_ok) |-> lands_in);

  assert_zero_size_linear_R4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_mode == 2'd1 && cur_size == '0) |-> (next_ptr == cur_ptr + cur_step));

  assert_linear_issues_ptr_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_mode == 2'd0) |=> (addr_out == $past(cur_ptr)));

  assert_bank_delay_R8: assert property (@(posedge clk) disable iff (rst)
    $stable(sel_stage) |=> $stable(sel_active));

endmodule

bind circbuf_agen circbuf_agen_chk #(.W(W), .SEGS(SEGS)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_mode   (req_mode),
  .addr_valid (addr_valid),
  .addr_out   (addr_out),
  .cur_ptr    (cur_ptr),
  .cur_step   (cur_step),
  .cur_start  (cur_start),
  .cur_size   (cur_size),
  .next_ptr   (next_ptr),
  .upd_en     (upd_en),
  .sel_stage  (sel_stage),
  .sel_active (sel_active)
);

// File: tb/circbuf_agen_tb_top.sv
module circbuf_agen_tb_top;

  localparam int W = 32;
  localparam int NVEC = 30;
  localparam int VW = 74;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  bank_mode = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_set = '0;
  logic [1:0]  wr_field = '0;
  logic [W-1:0] wr_data = '0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_set = '0;
  logic [1:0]  req_mode = '0;
  logic [W-1:0] req_imm = '0;
  logic        addr_valid;
  logic [W-1:0] addr_out;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  circbuf_agen dut_i (
    .clk(clk), .rst(rst), .bank_mode(bank_mode),
    .wr_en(wr_en), .wr_set(wr_set), .wr_field(wr_field), .wr_data(wr_data),
    .req_valid(req_valid), .req_set(req_set), .req_mode(req_mode), .req_imm(req_imm),
    .addr_valid(addr_valid), .addr_out(addr_out)
  );

  // Row: kind(1: 0 write, 1 access) | req tag(4) | set(3) | field or mode(2) | data or imm(32) | expected address(32)
  localparam logic [VW-1:0] VEC [NVEC] = '{
    {1'b0, 4'd2, 3'd1, 2'd0, 32'd100,        32'd0},
    {1'b0, 4'd2, 3'd1, 2'd1, 32'd3,          32'd0},
    {1'b0, 4'd2, 3'd1, 2'd2, 32'd100,        32'd0},
    {1'b0, 4'd2, 3'd1, 2'd3, 32'd10,         32'd0},
    {1'b0, 4'd2, 3'd2, 2'd0, 32'd50,         32'd0},
    {1'b0, 4'd2, 3'd2, 2'd1, 32'hFFFF_FFFC,  32'd0},
    {1'b0, 4'd2, 3'd2, 2'd2, 32'd48,         32'd0},
    {1'b0, 4'd2, 3'd2, 2'd3, 32'd8,          32'd0},
    {1'b0, 4'd2, 3'd3, 2'd0, 32'd1000,       32'd0},
    {1'b0, 4'd2, 3'd3, 2'd1, 32'd5,          32'd0},
    {1'b0, 4'd2, 3'd0, 2'd0, 32'd20,         32'd0},
    {1'b0, 4'd2, 3'd0, 2'd1, 32'd7,          32'd0},
    {1'b0, 4'd2, 3'd5, 2'd0, 32'd7,          32'd0},
    {1'b0, 4'd2, 3'd5, 2'd1, 32'd1,          32'd0},
    // R4 upward wrap: 109 + 3 leaves the buffer, comes back at 102
    {1'b1, 4'd4, 3'd1, 2'd1, 32'd0,          32'd100},
    {1'b1, 4'd4, 3'd1, 2'd1, 32'd0,          32'd103},
    {1'b1, 4'd4, 3'd1, 2'd1, 32'd0,          32'd106},
    {1'b1, 4'd4, 3'd1, 2'd1, 32'd0,          32'd109},
    {1'b1, 4'd4, 3'd1, 2'd1, 32'd0,          32'd102},
    // R4 downward wrap: 50 - 4 = 46 < 48, so 54
    {1'b1, 4'd4, 3'd2, 2'd1, 32'd0,          32'd50},
    {1'b1, 4'd4, 3'd2, 2'd1, 32'd0,          32'd54},
    {1'b1, 4'd4, 3'd2, 2'd1, 32'd0,          32'd50},
    // R4 size zero behaves linearly
    {1'b1, 4'd4, 3'd3, 2'd1, 32'd0,          32'd1000},
    {1'b1, 4'd4, 3'd3, 2'd1, 32'd0,          32'd1005},
    {1'b1, 4'd4, 3'd3, 2'd1, 32'd0,          32'd1010},
    // R3 linear, then R5 offset modes, then R5 pointer unchanged
    {1'b1, 4'd3, 3'd0, 2'd0, 32'd0,          32'd20},
    {1'b1, 4'd3, 3'd0, 2'd0, 32'd0,          32'd27},
    {1'b1, 4'd5, 3'd0, 2'd3, 32'd0,          32'd41},
    {1'b1, 4'd5, 3'd0, 2'd2, 32'd100,        32'd134},
    {1'b1, 4'd5, 3'd0, 2'd0, 32'd0,          32'd34}
  };

  task automatic check(input bit ok, input string tag, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Called at a negedge; returns at the negedge after the edge that takes the request.
  task automatic access(input logic [2:0] s, input logic [1:0] m, input logic [W-1:0] imm,
                        input logic [W-1:0] exp, input string tag);
    req_valid = 1'b1; req_set = s; req_mode = m; req_imm = imm;
    @(posedge clk); @(negedge clk);
    check(addr_valid === 1'b1, tag, W'(addr_valid), 1);
    check(addr_out === exp, tag, addr_out, exp);
    req_valid = 1'b0;
  endtask

  task automatic write_reg(input logic [2:0] s, input logic [1:0] f, input logic [W-1:0] d);
    wr_en = 1'b1; wr_set = s; wr_field = f; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    #(10 * 100000);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [VW-1:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state at the ports
    check(addr_valid === 1'b0, "R1 valid after reset", W'(addr_valid), 0);
    check(addr_out === '0, "R1 addr after reset", addr_out, 0);

    for (int i = 0; i < NVEC; i++) begin
      v = VEC[i];
      if (!v[73]) begin
        write_reg(v[68:66], v[65:64], v[63:32]);
        check(addr_valid === 1'b0, "R6 no valid on write row", W'(addr_valid), 0);
      end else begin
        access(v[68:66], v[65:64], v[63:32], v[31:0],
               $sformatf("R%0d vector %0d", v[72:69], i));
      end
    end

    // R1 an untouched set reads as all zero
    access(3'd4, 2'd0, '0, 32'd0, "R1 cleared set");

    // R8 switch half 1 to its alternate copy: two accesses still see the old copy
    bank_mode = 2'b10;
    access(3'd5, 2'd2, '0, 32'd7, "R8 first edge old copy");
    access(3'd5, 2'd2, '0, 32'd7, "R8 second edge old copy");
    access(3'd5, 2'd2, '0, 32'd0, "R7 alternate copy cleared");
    // R2 writes land in the active (alternate) copy
    write_reg(3'd5, 2'd0, 32'd500);
    access(3'd5, 2'd2, '0, 32'd500, "R2 write to alternate copy");
    // R7 half 0 still on its primary copy
    access(3'd0, 2'd2, '0, 32'd41, "R7 other half unchanged");
    bank_mode = 2'b00;
    @(posedge clk); @(posedge clk); @(negedge clk);
    access(3'd5, 2'd2, '0, 32'd7, "R7 primary copy restored");

    // R9 write and update on the same pointer at one edge
    wr_en = 1'b1; wr_set = 3'd3; wr_field = 2'd0; wr_data = 32'd2000;
    access(3'd3, 2'd0, '0, 32'd1015, "R9 old pointer issued");
    wr_en = 1'b0;
    access(3'd3, 2'd2, '0, 32'd2000, "R9 written value kept");

    // R6 idle cycle: valid drops, address holds
    @(posedge clk); @(negedge clk);
    check(addr_valid === 1'b0, "R6 idle valid", W'(addr_valid), 0);
    check(addr_out === 32'd2000, "R6 idle addr holds", addr_out, 32'd2000);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule